// File: doc/BRIEF.md
# Address-Space-Tagged Translation Lookaside Buffer

This block caches virtual-to-physical page translations for a processor whose page-table refill is handled by software. Each stored translation is keyed by a 20-bit virtual page number and a 6-bit address-space tag, so translations from different processes can live side by side. A context switch then only changes the tag presented with each lookup, and no flush is needed. Every entry is compared at the same time. A lookup that matches returns the physical frame joined with the page offset. A lookup that does not match reports a miss, and software answers the miss by writing a new entry.

The top three bits of the virtual address select a region. Two kernel windows skip translation and map straight onto physical memory, one cached and one uncached. User space and the upper kernel window go through the entry array. Software keeps the array up to date through three operations: a refill write (to an index it names, or to a round-robin pointer), invalidation of one specific translation, and a flush of all entries. Each entry keeps a reference bit and a dirty bit that lookups maintain. An entry that forbids writes turns a store into a write-permission fault.

Top module: `asid_tlb`

## Requirements
- R1: Each lookup accepted with `lk_valid` high gives exactly one response. `rsp_valid` rises on the clock edge that follows the lookup and is low in every other cycle, including the cycle after reset.
- R2: For a virtual address whose top bits are 0xx (user) or 11x (kernel mapped), a valid entry whose page number equals address bits [31:12] and whose tag equals `lk_asid` gives `rsp_hit`=1 and `rsp_paddr` = {entry frame, address bits [11:0]}.
- R3: A mapped lookup that matches no valid entry gives `rsp_miss`=1 and `rsp_hit`=0, and it changes no entry. After reset every entry is invalid.
- R4: For top bits 100, the response is `rsp_hit`=1, `rsp_uncached`=0 and `rsp_paddr` = the address with bits [31:29] cleared, whatever the entries hold.
- R5: For top bits 101, the response is the same as in R4 except that `rsp_uncached`=1. No other region sets `rsp_uncached`.
- R6: A write lookup (`lk_write`=1) that matches an entry refilled with `fill_writable`=0 gives `rsp_wfault`=1 and `rsp_hit`=0, and it does not set that entry's dirty bit.
- R7: An entry matches only when its stored tag equals `lk_asid`. The same page number stored under a different tag gives a miss.
- R8: `rsp_ref` and `rsp_dirty` report the matched entry's bits as they stood before the lookup. Any matching lookup sets the reference bit. A permitted write sets the dirty bit. A refill clears both bits.
- R9: A refill with `fill_use_idx`=1 writes entry `fill_idx`. With `fill_use_idx`=0 it writes the entry chosen by a pointer that is 0 after reset and advances by one (wrapping) after each such refill.
- R10: `inv_en` clears the valid bit of every entry whose page number equals `inv_vpn` and whose tag equals `inv_asid`, and leaves all other entries untouched.
- R11: `flush_en` invalidates every entry. A lookup in the cycle that follows a flush misses in the mapped regions. If a refill and a flush occur in the same cycle, the flush wins.
- R12: When several valid entries match, the lowest index supplies the frame and the permissions, and `rsp_multi`=1.
- R13: While `rsp_valid` is high, exactly one of `rsp_hit`, `rsp_miss` and `rsp_wfault` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| lk_valid | input | 1 | Lookup request |
| lk_vaddr | input | 32 | Virtual address to translate |
| lk_asid | input | 6 | Address-space tag of the lookup |
| lk_write | input | 1 | Lookup is a store |
| fill_en | input | 1 | Refill write |
| fill_use_idx | input | 1 | Use `fill_idx` instead of the round-robin pointer |
| fill_idx | input | 6 | Explicit refill index |
| fill_vpn | input | 20 | Page number of the new entry |
| fill_asid | input | 6 | Tag of the new entry |
| fill_pfn | input | 20 | Physical frame of the new entry |
| fill_writable | input | 1 | New entry permits writes |
| inv_en | input | 1 | Invalidate matching translation |
| inv_vpn | input | 20 | Page number to invalidate |
| inv_asid | input | 6 | Tag to invalidate |
| flush_en | input | 1 | Invalidate all entries |
| rsp_valid | output | 1 | Response present |
| rsp_paddr | output | 32 | Physical address (meaningful on hit) |
| rsp_hit | output | 1 | Translation or pass-through succeeded |
| rsp_miss | output | 1 | No matching entry; software refill needed |
| rsp_wfault | output | 1 | Store to a write-protected page |
| rsp_uncached | output | 1 | Address lies in the uncached physical window |
| rsp_multi | output | 1 | More than one entry matched |
| rsp_ref | output | 1 | Matched entry's reference bit before this lookup |
| rsp_dirty | output | 1 | Matched entry's dirty bit before this lookup |

## Verification
The assertions check on every cycle the rules that can be seen at the ports: the response timing, the exclusive outcome flags, the pass-through address and uncached flag of the two physical windows, the misses that follow a flush, and that a multiple-match flag never comes with a miss. Tag matching, address-space isolation, lowest-index priority, the reference and dirty updates, single-entry invalidation and round-robin placement all depend on what was written earlier. Only the bench's scenarios show them, by comparing every response with a model of the entry array that is updated along with the stimulus.

// File: rtl/tlb_pkg.sv
package tlb_pkg;
  typedef enum logic [1:0] {
    RGN_USER,
    RGN_PHYS_CACHED,
    RGN_PHYS_UNCACHED,
    RGN_KERN_VIRT
  } region_e;
endpackage

// File: rtl/tlb_region_dec.sv
module tlb_region_dec
  import tlb_pkg::*;
(
  input  logic [2:0] top_bits,
  output region_e    region,
  output logic       mapped,
  output logic       uncached
);
  always_comb begin
    case (top_bits)
      3'b100:         region = RGN_PHYS_CACHED;
      3'b101:         region = RGN_PHYS_UNCACHED;
      3'b110, 3'b111: region = RGN_KERN_VIRT;
      default:        region = RGN_USER;
    endcase
    mapped   = (region == RGN_USER) || (region == RGN_KERN_VIRT);
    uncached = (region == RGN_PHYS_UNCACHED);
  end
endmodule

// File: rtl/tlb_match.sv
module tlb_match #(
  parameter int N      = 64,
  parameter int VPN_W  = 20,
  parameter int ASID_W = 6
) (
  input  logic [N-1:0]      ent_valid,
  input  logic [VPN_W-1:0]  ent_vpn  [N],
  input  logic [ASID_W-1:0] ent_asid [N],
  input  logic [VPN_W-1:0]  key_vpn,
  input  logic [ASID_W-1:0] key_asid,
  output logic [N-1:0]      hit
);
  for (genvar g = 0; g < N; g++) begin : g_cmp
    assign hit[g] = ent_valid[g] && (ent_vpn[g] == key_vpn) && (ent_asid[g] == key_asid);
  end
endmodule

// File: rtl/tlb_prio.sv
module tlb_prio #(
  parameter int N = 64,
  localparam int IDX_W = $clog2(N)
) (
  input  logic [N-1:0]     req,
  output logic [IDX_W-1:0] idx,
  output logic             any,
  output logic             multi
);
  always_comb begin
    idx   = '0;
    any   = 1'b0;
    multi = 1'b0;
    for (int i = N - 1; i >= 0; i--) begin
      if (req[i]) idx = IDX_W'(i);
    end
    for (int i = 0; i < N; i++) begin
      if (req[i]) begin
        if (any) multi = 1'b1;
        any = 1'b1;
      end
    end
  end
endmodule

// File: rtl/asid_tlb.sv
module asid_tlb
  import tlb_pkg::*;
#(
  parameter int ENTRIES = 64,
  parameter int VPN_W   = 20,
  parameter int OFF_W   = 12,
  parameter int ASID_W  = 6,
  parameter int PFN_W   = 20
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       lk_valid,
  input  logic [VPN_W+OFF_W-1:0]     lk_vaddr,
  input  logic [ASID_W-1:0]          lk_asid,
  input  logic                       lk_write,
  input  logic                       fill_en,
  input  logic                       fill_use_idx,
  input  logic [$clog2(ENTRIES)-1:0] fill_idx,
  input  logic [VPN_W-1:0]           fill_vpn,
  input  logic [ASID_W-1:0]          fill_asid,
  input  logic [PFN_W-1:0]           fill_pfn,
  input  logic                       fill_writable,
  input  logic                       inv_en,
  input  logic [VPN_W-1:0]           inv_vpn,
  input  logic [ASID_W-1:0]          inv_asid,
  input  logic                       flush_en,
  output logic                       rsp_valid,
  output logic [PFN_W+OFF_W-1:0]     rsp_paddr,
  output logic                       rsp_hit,
  output logic                       rsp_miss,
  output logic                       rsp_wfault,
  output logic                       rsp_uncached,
  output logic                       rsp_multi,
  output logic                       rsp_ref,
  output logic                       rsp_dirty
);
  localparam int VA_W  = VPN_W + OFF_W;
  localparam int PA_W  = PFN_W + OFF_W;
  localparam int IDX_W = $clog2(ENTRIES);

  // entry state: tags and frames behave as simple write-only-on-refill arrays
  logic [ENTRIES-1:0] e_valid, e_ref, e_dirty, e_wr;
  logic [VPN_W-1:0]   e_vpn  [ENTRIES];
  logic [ASID_W-1:0]  e_asid [ENTRIES];
  logic [PFN_W-1:0]   e_pfn  [ENTRIES];

  logic [IDX_W-1:0]   rr_ptr;
  logic [IDX_W-1:0]   wr_idx;

  // lookup path
  region_e            lk_region;
  logic               lk_mapped, lk_unc;
  logic [VPN_W-1:0]   lk_vpn;
  logic [ENTRIES-1:0] lk_hitvec, inv_hitvec;
  logic [IDX_W-1:0]   sel_idx;
  logic               sel_any, sel_multi;
  logic               sel_wr;
  logic [ENTRIES-1:0] touch;

  assign lk_vpn = lk_vaddr[VA_W-1:OFF_W];
  assign wr_idx = fill_use_idx ? fill_idx : rr_ptr;

  tlb_region_dec u_rgn (
    .top_bits (lk_vaddr[VA_W-1:VA_W-3]),
    .region   (lk_region),
    .mapped   (lk_mapped),
    .uncached (lk_unc)
  );

  tlb_match #(.N(ENTRIES), .VPN_W(VPN_W), .ASID_W(ASID_W)) u_lk_cmp (
    .ent_valid (e_valid),
    .ent_vpn   (e_vpn),
    .ent_asid  (e_asid),
    .key_vpn   (lk_vpn),
    .key_asid  (lk_asid),
    .hit       (lk_hitvec)
  );

  tlb_match #(.N(ENTRIES), .VPN_W(VPN_W), .ASID_W(ASID_W)) u_inv_cmp (
    .ent_valid (e_valid),
    .ent_vpn   (e_vpn),
    .ent_asid  (e_asid),
    .key_vpn   (inv_vpn),
    .key_asid  (inv_asid),
    .hit       (inv_hitvec)
  );

  tlb_prio #(.N(ENTRIES)) u_prio (
    .req   (lk_hitvec),
    .idx   (sel_idx),
    .any   (sel_any),
    .multi (sel_multi)
  );

  assign sel_wr = e_wr[sel_idx];

  always_comb begin
    touch = '0;
    if (lk_valid && lk_mapped && sel_any) touch[sel_idx] = 1'b1;
  end

  // round-robin refill pointer
  always_ff @(posedge clk) begin
    if (rst) begin
      rr_ptr <= '0;
    end else if (fill_en && !fill_use_idx) begin
      if (rr_ptr == IDX_W'(ENTRIES - 1)) rr_ptr <= '0;
      else                               rr_ptr <= rr_ptr + 1'b1;
    end
  end

  // tag and frame arrays, written only by refill
  always_ff @(posedge clk) begin
    if (fill_en) begin
      e_vpn[wr_idx]  <= fill_vpn;
      e_asid[wr_idx] <= fill_asid;
      e_pfn[wr_idx]  <= fill_pfn;
    end
  end

  // per-entry flags
  always_ff @(posedge clk) begin
    if (rst) begin
      e_valid <= '0;
      e_ref   <= '0;
      e_dirty <= '0;
      e_wr    <= '0;
    end else begin
      for (int i = 0; i < ENTRIES; i++) begin
        if (flush_en) begin
          e_valid[i] <= 1'b0;
        end else if (fill_en && (wr_idx == IDX_W'(i))) begin
          e_valid[i] <= 1'b1;
          e_ref[i]   <= 1'b0;
          e_dirty[i] <= 1'b0;
          e_wr[i]    <= fill_writable;
        end else begin
          if (inv_en && inv_hitvec[i]) e_valid[i] <= 1'b0;
          if (touch[i])                e_ref[i]   <= 1'b1;
          if (touch[i] && lk_write && e_wr[i]) e_dirty[i] <= 1'b1;
        end
      end
    end
  end

  // registered response
  always_ff @(posedge clk) begin
    if (rst) begin
      rsp_valid    <= 1'b0;
      rsp_paddr    <= '0;
      rsp_hit      <= 1'b0;
      rsp_miss     <= 1'b0;
      rsp_wfault   <= 1'b0;
      rsp_uncached <= 1'b0;
      rsp_multi    <= 1'b0;
      rsp_ref      <= 1'b0;
      rsp_dirty    <= 1'b0;
    end else begin
      rsp_valid    <= lk_valid;
      rsp_paddr    <= '0;
      rsp_hit      <= 1'b0;
      rsp_miss     <= 1'b0;
      rsp_wfault   <= 1'b0;
      rsp_uncached <= 1'b0;
      rsp_multi    <= 1'b0;
      rsp_ref      <= 1'b0;
      rsp_dirty    <= 1'b0;
      if (lk_valid) begin
        if (!lk_mapped) begin
          rsp_hit      <= 1'b1;
          rsp_uncached <= lk_unc;
          rsp_paddr    <= PA_W'(lk_vaddr[VA_W-4:0]);
        end else if (!sel_any) begin
          rsp_miss <= 1'b1;
        end else begin
          rsp_multi <= sel_multi;
          rsp_ref   <= e_ref[sel_idx];
          rsp_dirty <= e_dirty[sel_idx];
          if (lk_write && !sel_wr) begin
            rsp_wfault <= 1'b1;
          end else begin
            rsp_hit   <= 1'b1;
            rsp_paddr <= {e_pfn[sel_idx], lk_vaddr[OFF_W-1:0]};
          end
        end
      end
    end
  end
endmodule

// File: rtl/asid_tlb_chk.sv
module asid_tlb_chk #(
  parameter int VA_W = 32,
  parameter int PA_W = 32
) (
  input logic            clk,
  input logic            rst,
  input logic            lk_valid,
  input logic [VA_W-1:0] lk_vaddr,
  input logic            flush_en,
  input logic            rsp_valid,
  input logic [PA_W-1:0] rsp_paddr,
  input logic            rsp_hit,
  input logic            rsp_miss,
  input logic            rsp_wfault,
  input logic            rsp_uncached,
  input logic            rsp_multi
);
  assert_rsp_timing_R1: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> (rsp_valid == $past(lk_valid)));

  assert_outcome_onehot_R13: assert property (@(posedge clk) disable iff (rst)
    rsp_valid |-> $countones({rsp_hit, rsp_miss, rsp_wfault}) == 1);

  assert_idle_quiet_R13: assert property (@(posedge clk) disable iff (rst)
    !rsp_valid |-> !(rsp_hit || rsp_miss || rsp_wfault || rsp_multi));

  assert_passthru_R4: assert property (@(posedge clk) disable iff (rst)
    (rsp_valid && !$past(rst) && $past(lk_vaddr[VA_W-1:VA_W-2]) == 2'b10)
      |-> (rsp_hit && rsp_paddr == PA_W'($past(lk_vaddr[VA_W-4:0]))));

  assert_uncached_R5: assert property (@(posedge clk) disable iff (rst)
    (rsp_valid && !$past(rst))
      |-> (rsp_uncached == ($past(lk_vaddr[VA_W-1:VA_W-3]) == 3'b101)));

  assert_flush_miss_R11: assert property (@(posedge clk) disable iff (rst)
    (rsp_valid && !$past(rst) && !$past(rst, 2) && $past(flush_en, 2)
      && $past(lk_vaddr[VA_W-1:VA_W-2]) != 2'b10) |-> rsp_miss);

  assert_multi_on_match_R12: assert property (@(posedge clk) disable iff (rst)
    rsp_multi |-> !rsp_miss);
endmodule

bind asid_tlb asid_tlb_chk #(.VA_W(VA_W), .PA_W(PA_W)) u_chk (
  .clk          (clk),
  .rst          (rst),
  .lk_valid     (lk_valid),
  .lk_vaddr     (lk_vaddr),
  .flush_en     (flush_en),
  .rsp_valid    (rsp_valid),
  .rsp_paddr    (rsp_paddr),
  .rsp_hit      (rsp_hit),
  .rsp_miss     (rsp_miss),
  .rsp_wfault   (rsp_wfault),
  .rsp_uncached (rsp_uncached),
  .rsp_multi    (rsp_multi)
);

// File: tb/asid_tlb_test.sv
module asid_tlb_test;
  localparam int CLK_PERIOD = 10;
  localparam int N = 64;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        lk_valid = 0, lk_write = 0;
  logic [31:0] lk_vaddr = '0;
  logic [5:0]  lk_asid = '0;
  logic        fill_en = 0, fill_use_idx = 0, fill_writable = 0;
  logic [5:0]  fill_idx = '0, fill_asid = '0;
  logic [19:0] fill_vpn = '0, fill_pfn = '0;
  logic        inv_en = 0;
  logic [19:0] inv_vpn = '0;
  logic [5:0]  inv_asid = '0;
  logic        flush_en = 0;
  logic        rsp_valid, rsp_hit, rsp_miss, rsp_wfault, rsp_uncached, rsp_multi, rsp_ref, rsp_dirty;
  logic [31:0] rsp_paddr;

  always #(CLK_PERIOD / 2) clk = ~clk;

  asid_tlb uut (
    .clk(clk), .rst(rst),
    .lk_valid(lk_valid), .lk_vaddr(lk_vaddr), .lk_asid(lk_asid), .lk_write(lk_write),
    .fill_en(fill_en), .fill_use_idx(fill_use_idx), .fill_idx(fill_idx),
    .fill_vpn(fill_vpn), .fill_asid(fill_asid), .fill_pfn(fill_pfn), .fill_writable(fill_writable),
    .inv_en(inv_en), .inv_vpn(inv_vpn), .inv_asid(inv_asid), .flush_en(flush_en),
    .rsp_valid(rsp_valid), .rsp_paddr(rsp_paddr), .rsp_hit(rsp_hit), .rsp_miss(rsp_miss),
    .rsp_wfault(rsp_wfault), .rsp_uncached(rsp_uncached), .rsp_multi(rsp_multi),
    .rsp_ref(rsp_ref), .rsp_dirty(rsp_dirty)
  );

  int checks = 0, fails = 0;
  bit done = 0;

  // reference model of the entry array
  logic        m_valid [N];
  logic        m_ref   [N];
  logic        m_dirty [N];
  logic        m_wr    [N];
  logic [19:0] m_vpn   [N];
  logic [5:0]  m_asid  [N];
  logic [19:0] m_pfn   [N];
  int          m_rr = 0;

  task automatic check(input string tag, input logic [39:0] got, input logic [39:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s got=%h expected=%h", tag, got, exp);
    end
  endtask

  task automatic do_fill(input bit use_idx, input int idx, input logic [19:0] vpn,
                         input logic [5:0] asid, input logic [19:0] pfn, input bit wr);
    int t;
    t = use_idx ? idx : m_rr;
    if (!use_idx) m_rr = (m_rr + 1) % N;
    m_valid[t] = 1; m_ref[t] = 0; m_dirty[t] = 0; m_wr[t] = wr;
    m_vpn[t] = vpn; m_asid[t] = asid; m_pfn[t] = pfn;
    @(negedge clk);
    fill_en = 1; fill_use_idx = use_idx; fill_idx = 6'(idx);
    fill_vpn = vpn; fill_asid = asid; fill_pfn = pfn; fill_writable = wr;
    @(negedge clk);
    fill_en = 0;
  endtask

  task automatic do_inv(input logic [19:0] vpn, input logic [5:0] asid);
    for (int i = 0; i < N; i++)
      if (m_valid[i] && m_vpn[i] == vpn && m_asid[i] == asid) m_valid[i] = 0;
    @(negedge clk);
    inv_en = 1; inv_vpn = vpn; inv_asid = asid;
    @(negedge clk);
    inv_en = 0;
  endtask

  task automatic do_flush();
    for (int i = 0; i < N; i++) m_valid[i] = 0;
    @(negedge clk);
    flush_en = 1;
    @(negedge clk);
    flush_en = 0;
  endtask

  task automatic lookup(input logic [31:0] va, input logic [5:0] asid, input bit wr, input string tag);
    logic e_hit, e_miss, e_wf, e_unc, e_multi, e_ref, e_dirty;
    logic [31:0] e_pa;
    int idx, cnt;
    logic [39:0] exp_v, got_v;
    e_hit = 0; e_miss = 0; e_wf = 0; e_unc = 0; e_multi = 0; e_ref = 0; e_dirty = 0;
    e_pa = '0; idx = -1; cnt = 0;
    if (va[31:30] == 2'b10) begin
      e_hit = 1; e_pa = {3'b000, va[28:0]}; e_unc = va[29];
    end else begin
      for (int i = 0; i < N; i++)
        if (m_valid[i] && m_vpn[i] == va[31:12] && m_asid[i] == asid) begin
          if (idx < 0) idx = i;
          cnt++;
        end
      if (idx < 0) e_miss = 1;
      else begin
        e_multi = (cnt > 1); e_ref = m_ref[idx]; e_dirty = m_dirty[idx];
        if (wr && !m_wr[idx]) e_wf = 1;
        else begin e_hit = 1; e_pa = {m_pfn[idx], va[11:0]}; end
        m_ref[idx] = 1;
        if (wr && m_wr[idx]) m_dirty[idx] = 1;
      end
    end
    @(negedge clk);
    lk_valid = 1; lk_vaddr = va; lk_asid = asid; lk_write = wr;
    @(negedge clk);
    lk_valid = 0; lk_write = 0;
    exp_v = {1'b1, e_hit, e_miss, e_wf, e_unc, e_multi, e_ref, e_dirty, e_pa};
    got_v = {rsp_valid, rsp_hit, rsp_miss, rsp_wfault, rsp_uncached, rsp_multi, rsp_ref, rsp_dirty,
             e_hit ? rsp_paddr : 32'h0};
    check(tag, got_v, exp_v);
  endtask

  function automatic logic [19:0] pick_vpn();
    return {($urandom % 2) ? 3'b110 : 3'b000, 13'd0, 4'($urandom % 16)};
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog expired got=hung expected=finished");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20241));
    for (int i = 0; i < N; i++) begin
      m_valid[i] = 0; m_ref[i] = 0; m_dirty[i] = 0; m_wr[i] = 0;
      m_vpn[i] = '0; m_asid[i] = '0; m_pfn[i] = '0;
    end
    repeat (4) @(negedge clk);
    rst = 0;
    @(negedge clk);
    // R1: no response after reset without a lookup
    check("R1 reset idle", {32'h0, rsp_valid, rsp_hit, rsp_miss, rsp_wfault, 4'h0}, 40'h0);
    lookup(32'h0000_5123, 6'd1, 0, "R3 empty after reset");
    lookup(32'h8123_4567, 6'd0, 0, "R4 cached window");
    lookup(32'hBFFF_FFFC, 6'd3, 1, "R5 uncached window");
    // R9: round-robin placement then explicit overwrite of slot 1
    do_fill(0, 0, 20'h00011, 6'd2, 20'hAAAA1, 1);
    do_fill(0, 0, 20'h00022, 6'd2, 20'hAAAA2, 0);
    do_fill(1, 1, 20'h00033, 6'd2, 20'hAAAA3, 1);
    lookup(32'h0002_2010, 6'd2, 0, "R9 overwritten slot misses");
    lookup(32'h0001_1ABC, 6'd2, 0, "R2 user hit");
    lookup(32'h0001_1ABC, 6'd2, 0, "R8 reference set");
    lookup(32'h0001_1004, 6'd2, 1, "R8 write sets dirty");
    lookup(32'h0001_1008, 6'd2, 0, "R8 dirty reported");
    lookup(32'h0001_1ABC, 6'd5, 0, "R7 other tag misses");
    do_fill(1, 7, 20'hC0044, 6'd9, 20'h12345, 0);
    lookup(32'hC004_4FF0, 6'd9, 0, "R2 kernel mapped hit");
    lookup(32'hC004_4FF0, 6'd9, 1, "R6 write to read-only");
    lookup(32'hC004_4FF0, 6'd9, 0, "R6 dirty stays clear");
    do_fill(1, 9, 20'h00055, 6'd1, 20'hBBBB9, 1);
    do_fill(1, 5, 20'h00055, 6'd1, 20'hBBBB5, 1);
    lookup(32'h0005_5321, 6'd1, 0, "R12 lowest index wins");
    do_inv(20'h00055, 6'd1);
    lookup(32'h0005_5321, 6'd1, 0, "R10 invalidated");
    lookup(32'h0003_3000, 6'd2, 0, "R10 others untouched");
    do_flush();
    lookup(32'h0003_3000, 6'd2, 0, "R11 flushed");
    lookup(32'hC004_4000, 6'd9, 0, "R11 flushed kernel");
    // R9: pointer continues at 2 after the flush
    do_fill(0, 0, 20'h00066, 6'd4, 20'hCCCC6, 1);
    do_fill(1, 2, 20'h00077, 6'd4, 20'hCCCC7, 1);
    lookup(32'h0006_6000, 6'd4, 0, "R9 pointer position");
    // random mix
    for (int it = 0; it < 600; it++) begin
      int op;
      op = $urandom % 12;
      if (op < 3) do_fill(($urandom % 2) == 1, $urandom % 8, pick_vpn(), 6'($urandom % 3),
                          20'($urandom), ($urandom % 3) != 0);
      else if (op == 3) do_inv(pick_vpn(), 6'($urandom % 3));
      else if (op == 4 && ($urandom % 20) == 0) do_flush();
      else if (op == 5) lookup({2'b10, 30'($urandom)}, 6'($urandom % 3), ($urandom % 2) == 1, "R5 random window");
      else lookup({pick_vpn(), 12'($urandom)}, 6'($urandom % 3), ($urandom % 2) == 1, "R13 random mapped");
    end
    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule